// File: doc/BRIEF.md
# Two-Lane Interleaved Word Serializer

This block turns a wide parallel value into a stream of narrow words. A load strobe captures a 128-bit value. The block then sends it out as eight 16-bit words on consecutive clock cycles, starting with the most significant word.

Internally the eight words are shared out between two lanes of storage. One lane holds the even-numbered words and the other holds the odd-numbered words. A phase toggle enables the lanes in turn, so each lane register shifts on only every other cycle. This means the logic of each lane only has to keep up with half the output word rate. A registered output selector takes the head word of each lane in turn to rebuild the full-rate stream.

A ready flag shows when a new load will be accepted. Ready is high while the last word is being sent, so a load in that cycle continues the stream with no idle cycle between the two values.

Top module: `ilv_serializer`

## Requirements
- R1: When `load` is high and `ready` is high at a rising clock edge, the block captures `load_data` and starts a new sequence of eight words.
- R2: Word k of a sequence (k = 0..7) is `load_data[127-16k : 112-16k]`. Word 0 appears on `word_out` after the first rising edge following the load edge. Each later word follows one cycle after the one before it.
- R3: Words 0, 2, 4 and 6 come from the even lane and words 1, 3, 5 and 7 come from the odd lane. The lane enables are never both high. While a sequence runs, the phase toggle changes on every cycle.
- R4: An accepted load sets the phase toggle to even. This makes word 0 the first word after every load, including a load that follows straight on from the previous sequence.
- R5: `word_valid` is high in exactly the cycles where `word_out` carries a word of a sequence.
- R6: `ready` is high when no sequence is running, and it is high in the cycle before word 7 appears. A load accepted in that cycle makes word 0 of the new value appear in the cycle after word 7, with `word_valid` staying high.
- R7: A load that arrives while `ready` is low is ignored. The running sequence continues unchanged.
- R8: When a sequence ends with no new load, `word_valid` goes low one cycle after word 7 appears, and `word_out` keeps showing word 7.
- R9: Asserting `rst_n` low clears all lane storage and `word_out` to zero at once, without waiting for a clock edge. After reset, `word_valid` is 0 and `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Load strobe |
| load_data | input | 128 | Parallel value to serialize |
| word_out | output | 16 | Current output word |
| word_valid | output | 1 | High while `word_out` carries a sequence word |
| ready | output | 1 | A load in this cycle will be accepted |

## Verification
The bench goes after the ordering of the two lanes. If the lane split were wrong, or the phase did not start at even after a load, the stream would show swapped neighbouring words or start with word 1. The bench also tests a load placed exactly in the ready cycle. A design that opened ready one cycle late would leave a gap, and a design that skipped the phase reset would start the new value on the odd lane. A load placed in the middle of a sequence must not corrupt the words still to come. An asynchronous reset applied between clock edges must clear the output at once.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned DEF_WORD_W  = 16;
  localparam int unsigned DEF_N_WORDS = 8;

  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_t;

  // Bit offset of the low end of word k when word 0 sits at the top of the vector
  function automatic int unsigned word_lsb(int unsigned k, int unsigned n_words,
                                           int unsigned word_w);
    return (n_words - 1 - k) * word_w;
  endfunction
endpackage

// File: rtl/ilv_phase_ctrl.sv
module ilv_phase_ctrl
  import ilv_pkg::*;
#(
  parameter int unsigned N_WORDS = DEF_N_WORDS
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  output logic   load_acc,
  output logic   busy,
  output phase_t phase,
  output logic   even_en,
  output logic   odd_en,
  output logic   ready
);
  localparam int unsigned CNT_W = $clog2(N_WORDS);

  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last     = busy && (cnt == CNT_W'(N_WORDS - 1));
  assign ready    = !busy || last;
  assign load_acc = load && ready;
  assign even_en  = busy && (phase == PH_EVEN);
  assign odd_en   = busy && (phase == PH_ODD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      phase <= PH_EVEN;
    end else if (load_acc) begin
      busy  <= 1'b1;
      cnt   <= '0;
      phase <= PH_EVEN;
    end else if (busy) begin
      cnt   <= cnt + 1'b1;
      phase <= (phase == PH_EVEN) ? PH_ODD : PH_EVEN;
      if (last) busy <= 1'b0;
    end
  end

  // R3
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_acc) |=> (phase != $past(phase)));

  // R4
  load_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> (phase == PH_EVEN && busy));

  // R7
  ignore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ready) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane
  import ilv_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned DEPTH  = DEF_N_WORDS / 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [DEPTH*WORD_W-1:0] load_val,
  input  logic                    shift_en,
  output logic [WORD_W-1:0]       head
);
  localparam int unsigned LANE_W = DEPTH * WORD_W;

  logic [LANE_W-1:0] store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        store <= '0;
    else if (load)     store <= load_val;
    else if (shift_en) store <= store << WORD_W;
  end

  assign head = store[LANE_W-1 -: WORD_W];
endmodule

// File: rtl/ilv_out_mux.sv
module ilv_out_mux
  import ilv_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  phase_t            phase,
  input  logic [WORD_W-1:0] even_head,
  input  logic [WORD_W-1:0] odd_head,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= busy;
      if (busy) word_out <= (phase == PH_ODD) ? odd_head : even_head;
    end
  end

  // R5
  valid_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> word_valid);

  // R8
  valid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !word_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(word_out));
endmodule

// File: rtl/ilv_serializer.sv
module ilv_serializer
  import ilv_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned N_WORDS = DEF_N_WORDS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [N_WORDS*WORD_W-1:0] load_data,
  output logic [WORD_W-1:0]         word_out,
  output logic                      word_valid,
  output logic                      ready
);
  localparam int unsigned LANE_WORDS = N_WORDS / 2;
  localparam int unsigned LANE_W     = LANE_WORDS * WORD_W;

  logic              load_acc, busy, even_en, odd_en;
  phase_t            phase;
  logic [LANE_W-1:0] lane_init [2];
  logic [WORD_W-1:0] lane_head [2];
  logic              lane_en   [2];

  ilv_phase_ctrl #(.N_WORDS(N_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .load_acc(load_acc),
    .busy(busy), .phase(phase), .even_en(even_en), .odd_en(odd_en),
    .ready(ready)
  );

  assign lane_en[0] = even_en;
  assign lane_en[1] = odd_en;

  // Lane p takes words p, p+2, p+4, ... with the earliest at its head
  for (genvar p = 0; p < 2; p++) begin : g_lane
    for (genvar j = 0; j < LANE_WORDS; j++) begin : g_slot
      assign lane_init[p][(LANE_WORDS-1-j)*WORD_W +: WORD_W] =
        load_data[word_lsb(2*j + p, N_WORDS, WORD_W) +: WORD_W];
    end

    ilv_lane #(.WORD_W(WORD_W), .DEPTH(LANE_WORDS)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(load_acc), .load_val(lane_init[p]),
      .shift_en(lane_en[p]), .head(lane_head[p])
    );
  end

  ilv_out_mux #(.WORD_W(WORD_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .busy(busy), .phase(phase),
    .even_head(lane_head[0]), .odd_head(lane_head[1]),
    .word_out(word_out), .word_valid(word_valid)
  );

  // R3
  en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({even_en, odd_en}));

  // R6
  gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_acc && busy) |=> ##1 word_valid);
endmodule

// File: tb/ilv_serializer_tb.sv
module ilv_serializer_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [127:0] load_data = '0;
  logic [15:0]  word_out;
  logic         word_valid, ready;
  int           checks = 0;
  int           errors = 0;

  ilv_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .word_out(word_out), .word_valid(word_valid), .ready(ready)
  );

  always #10 clk = ~clk;

  localparam logic [127:0] VECS [0:2] = '{
    128'h0001_0002_0003_0004_0005_0006_0007_0008,
    128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0,
    128'hFFFF_0000_A5A5_5A5A_8001_7FFE_00FF_FF00
  };

  function automatic logic [15:0] nth(input logic [127:0] d, input int k);
    return 16'(d >> (16 * (7 - k)));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_load(input logic [127:0] d);
    @(negedge clk); load = 1'b1; load_data = d;
    @(negedge clk); load = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #15;
    chk("R9 reset word", word_out, 16'h0);
    chk("R9 reset valid", 16'(word_valid), 16'h0);
    chk("R9 reset ready", 16'(ready), 16'h1);
    @(negedge clk); rst_n = 1'b1;

    // Table walk: R1 R2 R3 R5 R6 R8
    for (int v = 0; v < 3; v++) begin
      pulse_load(VECS[v]);
      chk("R1 busy after load", 16'(ready), 16'h0);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        chk("R2 R3 word order", word_out, nth(VECS[v], k));
        chk("R5 valid during seq", 16'(word_valid), 16'h1);
        chk("R6 ready", 16'(ready), 16'(k >= 6));
      end
      @(negedge clk);
      chk("R8 valid drops", 16'(word_valid), 16'h0);
      chk("R8 word holds", word_out, nth(VECS[v], 7));
      @(negedge clk);
      chk("R8 word still held", word_out, nth(VECS[v], 7));
    end

    // R7: load during a running sequence is ignored
    pulse_load(VECS[0]);
    @(negedge clk);
    chk("R7 first word", word_out, nth(VECS[0], 0));
    load = 1'b1; load_data = VECS[1];
    @(negedge clk); load = 1'b0;
    for (int k = 1; k < 8; k++) begin
      if (k > 1) @(negedge clk);
      chk("R7 ignored load", word_out, nth(VECS[0], k));
    end
    @(negedge clk);
    chk("R7 no restart", 16'(word_valid), 16'h0);

    // R6 R4: back-to-back load in the ready cycle
    pulse_load(VECS[1]);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      chk("R6 first stream", word_out, nth(VECS[1], k));
    end
    chk("R6 ready before last", 16'(ready), 16'h1);
    load = 1'b1; load_data = VECS[2];
    @(negedge clk); load = 1'b0;
    chk("R6 last old word", word_out, nth(VECS[1], 7));
    chk("R6 busy again", 16'(ready), 16'h0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R4 new stream from word 0", word_out, nth(VECS[2], k));
      chk("R6 no gap", 16'(word_valid), 16'h1);
    end
    @(negedge clk);

    // R9: asynchronous reset mid-sequence
    pulse_load(VECS[1]);
    @(negedge clk); @(negedge clk);
    #5 rst_n = 1'b0;
    #2;
    chk("R9 async word", word_out, 16'h0);
    chk("R9 async valid", 16'(word_valid), 16'h0);
    chk("R9 async ready", 16'(ready), 16'h1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 stays idle", 16'(word_valid), 16'h0);
    chk("R9 word cleared", word_out, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule